// File: doc/BRIEF.md
# Stack Expression Evaluator

This block evaluates arithmetic written for a zero-address machine. The caller sends a stream of commands over a valid/ready handshake. Each command carries a 3-bit opcode and, for a push, a 16-bit immediate. Operands live in an on-chip last-in, first-out stack of sixteen 16-bit two's-complement entries. Every arithmetic command takes its operands implicitly from the two topmost entries. It removes both and leaves a single result in their place, so each binary command lowers the depth by one.

A pop returns the top entry on a result port, with a one-cycle valid strobe. Add, subtract and multiply finish in the cycle they are accepted. Divide runs a bit-serial restoring divider, and the command input stays not-ready until the quotient has been written back. Three sticky flags record a push on a full stack, a command that needed more entries than were present, and a division by zero. Only reset clears these flags.

Top module: `stack_eval`

## Requirements
- R1: A PUSH (opcode 0) stores cmd_imm as the new top. A POP (opcode 1) removes the top and drives it on res_data, with res_valid high for the one cycle after acceptance. Values come back most-recent first.
- R2: ADD (opcode 2) replaces the two top entries with their sum, modulo 2^16.
- R3: SUB (opcode 3) replaces the two top entries with (top minus the entry beneath it). Pushing 10 and then 3 gives -7.
- R4: MUL (opcode 4) replaces the two top entries with the low 16 bits of their product.
- R5: DIV (opcode 5) replaces the two top entries with (entry beneath the top) divided by (top), as a signed quotient truncated toward zero, modulo 2^16. With a nonzero divisor, cmd_ready stays low for exactly 17 cycles after acceptance.
- R6: A DIV whose top entry is zero sets the sticky dz_flag, consumes both operands and pushes 0.
- R7: A PUSH while 16 entries are held is ignored and sets the sticky ovf_flag. All stored values are kept.
- R8: A POP on an empty stack, or any binary command with fewer than two entries, leaves the stack unchanged and sets the sticky unf_flag. Such a POP raises no res_valid.
- R9: After reset the stack is empty, cmd_ready is high, and res_valid and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div |
| cmd_imm | input | 16 | Value for a push |
| res_valid | output | 1 | One-cycle strobe for a popped value |
| res_data | output | 16 | Popped value |
| ovf_flag | output | 1 | Sticky push-on-full flag |
| unf_flag | output | 1 | Sticky too-few-entries flag |
| dz_flag | output | 1 | Sticky divide-by-zero flag |

## Verification
The bench checks operand order for subtraction and division. A design with the order swapped would return 10-3 instead of 3-10, or 2/7 instead of 7/2. Signed division is driven with negative dividends and with -32768 divided by -1. A divider that got the sign handling wrong would round toward minus infinity or saturate instead of wrapping. The bench fills the stack to exactly sixteen entries, pushes once more, pops on empty, and adds with a single entry. A design with an off-by-one limit would flag too early or corrupt the bottom entry. A design that altered state on an underflow would lose the surviving value or emit a spurious result strobe. Random streams, reset at intervals, compare every pop and every flag against a bench-side model.

// File: rtl/stack_eval_pkg.sv
package stack_eval_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DIVW = 1'b1
  } ctl_e;
endpackage

// File: rtl/stack_eval_lifo.sv
module stack_eval_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         do_push,
  input  logic                         do_pop,
  input  logic                         do_fold,
  input  logic [W-1:0]                 wr_data,
  output logic [W-1:0]                 top_q,
  output logic [W-1:0]                 next_q,
  output logic [$clog2(DEPTH+1)-1:0]   count_q
);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] count_d;

  // entry write enables: push writes slot count, fold writes slot count-2
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wen;
    assign wen = (do_push && (count_q == CW'(i))) ||
                 (do_fold && (count_q == CW'(i + 2)));
    always_ff @(posedge clk) begin
      if (wen) mem[i] <= wr_data;
    end
  end

  always_comb begin
    top_q  = '0;
    next_q = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count_q == CW'(i + 1)) top_q  = mem[i];
      if (count_q == CW'(i + 2)) next_q = mem[i];
    end
  end

  always_comb begin
    count_d = count_q;
    if (do_push)      count_d = count_q + CW'(1);
    else if (do_pop)  count_d = count_q - CW'(1);
    else if (do_fold) count_d = count_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end
endmodule

// File: rtl/stack_eval_alu.sv
module stack_eval_alu
  import stack_eval_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] top,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] result
);
  logic [2*W-1:0] prod;

  assign prod = top * nxt;

  always_comb begin
    case (op)
      OP_ADD:  result = nxt + top;
      OP_SUB:  result = top - nxt;
      OP_MUL:  result = prod[W-1:0];
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/stack_eval_div.sv
module stack_eval_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int NW = (W > 1) ? $clog2(W) : 1;

  logic          busy_q, busy_d, done_q, done_d, neg_q, neg_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic [W:0]    shifted, diff;
  logic          fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign fits    = ~diff[W];

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    neg_d  = neg_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      rem_d  = '0;
      quo_d  = dividend[W-1] ? -dividend : dividend;
      dvs_d  = divisor[W-1]  ? -divisor  : divisor;
      neg_d  = dividend[W-1] ^ divisor[W-1];
    end else if (busy_q) begin
      rem_d = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
      cnt_d = cnt_q + NW'(1);
      if (cnt_q == NW'(W - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start || busy_q) begin
      neg_q <= neg_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = neg_q ? -quo_q : quo_q;
endmodule

// File: rtl/stack_eval.sv
module stack_eval
  import stack_eval_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_imm,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         ovf_flag,
  output logic         unf_flag,
  output logic         dz_flag
);
  localparam int CW = $clog2(DEPTH+1);

  ctl_e          state_q, state_d;
  logic [CW-1:0] stk_count;
  logic [W-1:0]  stk_top, stk_next, alu_res, div_q, fold_data;
  logic          div_busy, div_done, div_start;
  logic          accept, is_bin, full, empty, has_two;
  logic          push_ok, pop_ok, bin_ok, div_zero, fold_now;
  logic          ovf_set, unf_set;
  logic          res_valid_q, ovf_q, unf_q, dz_q;
  logic [W-1:0]  res_data_q;

  assign accept  = cmd_valid && cmd_ready;
  assign is_bin  = (cmd_op == OP_ADD) || (cmd_op == OP_SUB) ||
                   (cmd_op == OP_MUL) || (cmd_op == OP_DIV);
  assign full    = (stk_count == CW'(DEPTH));
  assign empty   = (stk_count == '0);
  assign has_two = (stk_count >= CW'(2));

  assign push_ok   = accept && (cmd_op == OP_PUSH) && !full;
  assign pop_ok    = accept && (cmd_op == OP_POP) && !empty;
  assign bin_ok    = accept && is_bin && has_two;
  assign div_zero  = bin_ok && (cmd_op == OP_DIV) && (stk_top == '0);
  assign div_start = bin_ok && (cmd_op == OP_DIV) && (stk_top != '0);
  assign fold_now  = bin_ok && (cmd_op != OP_DIV);
  assign ovf_set   = accept && (cmd_op == OP_PUSH) && full;
  assign unf_set   = accept && (((cmd_op == OP_POP) && empty) ||
                                (is_bin && !has_two));

  // quotient from the divider wins; a zero divisor folds in the ALU's zero
  assign fold_data = div_done ? div_q : (push_ok ? cmd_imm : alu_res);

  stack_eval_lifo #(.W(W), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .do_push (push_ok),
    .do_pop  (pop_ok),
    .do_fold (fold_now || div_zero || div_done),
    .wr_data (fold_data),
    .top_q   (stk_top),
    .next_q  (stk_next),
    .count_q (stk_count)
  );

  stack_eval_alu #(.W(W)) u_alu (
    .op     (cmd_op),
    .top    (stk_top),
    .nxt    (stk_next),
    .result (alu_res)
  );

  stack_eval_div #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (stk_next),
    .divisor  (stk_top),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_q)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (div_start) state_d = ST_DIVW;
      ST_DIVW: if (div_done)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      res_valid_q <= 1'b0;
      ovf_q       <= 1'b0;
      unf_q       <= 1'b0;
      dz_q        <= 1'b0;
    end else begin
      state_q     <= state_d;
      res_valid_q <= pop_ok;
      if (ovf_set)  ovf_q <= 1'b1;
      if (unf_set)  unf_q <= 1'b1;
      if (div_zero) dz_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pop_ok) res_data_q <= stk_top;
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign res_valid = res_valid_q;
  assign res_data  = res_data_q;
  assign ovf_flag  = ovf_q;
  assign unf_flag  = unf_q;
  assign dz_flag   = dz_q;
endmodule

// File: rtl/stack_eval_chk.sv
module stack_eval_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic [2:0]                 cmd_op,
  input logic                       res_valid,
  input logic                       ovf_flag,
  input logic                       unf_flag,
  input logic                       dz_flag,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       div_busy
);
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);

  a_r6_dz_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dz_flag |=> dz_flag);

  a_r1_res_needs_pop: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(cmd_valid && cmd_ready && cmd_op == 3'd1));

  a_r8_empty_pop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd1 && count == '0) |=> !res_valid);

  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !cmd_ready);

  a_r6_dz_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dz_flag) |-> $past(cmd_valid && cmd_ready && cmd_op == 3'd5));

  a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(cmd_valid && cmd_ready && cmd_op == 3'd0));
endmodule

bind stack_eval stack_eval_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .res_valid (res_valid),
  .ovf_flag  (ovf_flag),
  .unf_flag  (unf_flag),
  .dz_flag   (dz_flag),
  .count     (stk_count),
  .div_busy  (div_busy)
);

// File: tb/stack_eval_test.sv
module stack_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_imm = 16'd0;
  logic        res_valid;
  logic [15:0] res_data;
  logic        ovf_flag, unf_flag, dz_flag;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  logic [15:0] m [16];
  int          mc;
  logic        e_ovf, e_unf, e_dz;

  stack_eval uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_imm(cmd_imm), .res_valid(res_valid),
    .res_data(res_data), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .dz_flag(dz_flag)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary();
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [15:0] ref_op(input logic [2:0] op,
                                         input logic [15:0] t,
                                         input logic [15:0] n);
    int si, ni;
    logic [31:0] p;
    si = int'($signed(t));
    ni = int'($signed(n));
    case (op)
      3'd2: ref_op = n + t;
      3'd3: ref_op = t - n;
      3'd4: begin p = 32'(ni * si); ref_op = p[15:0]; end
      3'd5: ref_op = (t == 16'd0) ? 16'd0 : 16'(ni / si);
      default: ref_op = 16'd0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mc = 0;
    e_ovf = 0; e_unf = 0; e_dz = 0;
  endtask

  // issue one command; on return it is the negedge after acceptance
  task automatic do_cmd(input logic [2:0] op, input logic [15:0] imm,
                        output logic [15:0] popped);
    logic        ev;
    logic [15:0] er, t, n;
    ev = 0; er = 0; popped = 0;
    case (op)
      3'd0: if (mc == 16) e_ovf = 1; else begin m[mc] = imm; mc++; end
      3'd1: if (mc == 0) e_unf = 1; else begin mc--; ev = 1; er = m[mc]; end
      3'd2, 3'd3, 3'd4, 3'd5:
        if (mc < 2) e_unf = 1;
        else begin
          t = m[mc-1]; n = m[mc-2];
          if (op == 3'd5 && t == 16'd0) e_dz = 1;
          m[mc-2] = ref_op(op, t, n);
          mc--;
        end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_imm = imm;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(res_valid == ev, (ev ? "R1 pop strobe" : "R8 no strobe"), int'(res_valid), int'(ev));
    if (ev) chk(res_data == er, "R1 pop value", int'(res_data), int'(er));
    popped = res_data;
    chk(ovf_flag == e_ovf, "R7 ovf_flag", int'(ovf_flag), int'(e_ovf));
    chk(unf_flag == e_unf, "R8 unf_flag", int'(unf_flag), int'(e_unf));
    chk(dz_flag == e_dz, "R6 dz_flag", int'(dz_flag), int'(e_dz));
  endtask

  task automatic push(input logic [15:0] v);
    logic [15:0] d;
    do_cmd(3'd0, v, d);
  endtask

  task automatic op2(input logic [2:0] op);
    logic [15:0] d;
    do_cmd(op, 16'd0, d);
  endtask

  task automatic expect_pop(input logic [15:0] v, input string req);
    logic [15:0] d;
    do_cmd(3'd1, 16'd0, d);
    chk(d == v, req, int'(d), int'(v));
  endtask

  function automatic logic [15:0] rand_val();
    case ($urandom % 6)
      0: rand_val = 16'd0;
      1: rand_val = 16'hFFFF;
      2: rand_val = 16'h8000;
      3: rand_val = 16'h7FFF;
      4: rand_val = 16'($urandom % 9) - 16'd4;
      default: rand_val = 16'($urandom);
    endcase
  endfunction

  initial begin
    int wait_cnt;
    logic [15:0] d;
    void'($urandom(32'd20240611));
    mc = 0; e_ovf = 0; e_unf = 0; e_dz = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(cmd_ready == 1'b1, "R9 ready", int'(cmd_ready), 1);
    chk(res_valid == 1'b0, "R9 res_valid", int'(res_valid), 0);
    chk({ovf_flag, unf_flag, dz_flag} == 3'b000, "R9 flags",
        int'({ovf_flag, unf_flag, dz_flag}), 0);

    // R1 ordering
    push(16'd5); push(16'd9); push(16'hFFFD);
    expect_pop(16'hFFFD, "R1 lifo"); expect_pop(16'd9, "R1 lifo"); expect_pop(16'd5, "R1 lifo");

    // R3 operand order
    push(16'd10); push(16'd3); op2(3'd3);
    expect_pop(16'hFFF9, "R3 sub order");

    // R2 wrap
    push(16'h7FFF); push(16'd1); op2(3'd2);
    expect_pop(16'h8000, "R2 add wrap");

    // R4 low product bits
    push(16'd300); push(16'd300); op2(3'd4);
    expect_pop(16'h5F90, "R4 mul low");
    push(16'hFFFE); push(16'd3); op2(3'd4);
    expect_pop(16'hFFFA, "R4 mul signed");

    // R5 division order, sign and busy window
    push(16'd7); push(16'd2); op2(3'd5);
    chk(cmd_ready == 1'b0, "R5 ready low", int'(cmd_ready), 0);
    wait_cnt = 1;
    while (!cmd_ready && wait_cnt < 100) begin @(negedge clk); if (!cmd_ready) wait_cnt++; end
    chk(wait_cnt == 17, "R5 busy cycles", wait_cnt, 17);
    expect_pop(16'd3, "R5 div order");
    push(16'hFFF9); push(16'd2); op2(3'd5);
    expect_pop(16'hFFFD, "R5 div trunc");
    push(16'h8000); push(16'hFFFF); op2(3'd5);
    expect_pop(16'h8000, "R5 div wrap");

    // R6 divide by zero
    push(16'd9); push(16'd0); op2(3'd5);
    chk(dz_flag == 1'b1, "R6 dz set", int'(dz_flag), 1);
    expect_pop(16'd0, "R6 zero pushed");

    // R7 overflow
    do_reset();
    for (int i = 0; i < 16; i++) push(16'(i * 3 + 1));
    chk(ovf_flag == 1'b0, "R7 no early ovf", int'(ovf_flag), 0);
    push(16'hBEEF);
    chk(ovf_flag == 1'b1, "R7 ovf set", int'(ovf_flag), 1);
    for (int i = 15; i >= 0; i--) expect_pop(16'(i * 3 + 1), "R7 contents kept");

    // R8 underflow
    do_reset();
    do_cmd(3'd1, 16'd0, d);
    chk(unf_flag == 1'b1, "R8 pop empty", int'(unf_flag), 1);
    do_reset();
    push(16'd4); op2(3'd2);
    chk(unf_flag == 1'b1, "R8 add short", int'(unf_flag), 1);
    expect_pop(16'd4, "R8 entry kept");

    // random mix against the model
    do_reset();
    for (int k = 0; k < 2500; k++) begin
      int r;
      if (k % 300 == 299) do_reset();
      r = int'($urandom % 100);
      if (r < 40)      push(rand_val());
      else if (r < 60) do_cmd(3'd1, 16'd0, d);
      else if (r < 70) op2(3'd2);
      else if (r < 80) op2(3'd3);
      else if (r < 90) op2(3'd4);
      else             op2(3'd5);
    end

    summary();
  end
endmodule